// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A load cycle captures a full starting address from the external address bus. Each following advance cycle steps the two lowest address bits to the next beat and leaves the upper bits where they were. The step order is picked by a static mode input. Linear order adds the beat count to the start value modulo four. Interleaved order XORs the start value with the beat count. Both orders can begin at any of the four offsets. After the fourth beat, both return to the starting offset.

A clock-enable stall freezes the address and the beat index for as long as it is held, and all other inputs are ignored while it is held. Command decode, data steering and the storage array are outside this block. The parent drives a load on every new access and an advance on every burst continuation. It uses the registered address and beat index as they come out.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `acc_addr` = 0 and `beat_idx` = 0.
- R2: A cycle with `hold` = 0 and `adv` = 0 is a load: after that edge `acc_addr` equals the `ext_addr` sampled at the edge and `beat_idx` is 0.
- R3: With `ilv_mode` = 0 (linear), each advance cycle (`hold` = 0, `adv` = 1) leaves `acc_addr[1:0]` = (start[1:0] + beat_idx) mod 4.
- R4: With `ilv_mode` = 1 (interleaved), each advance cycle leaves `acc_addr[1:0]` = start[1:0] XOR beat_idx.
- R5: `beat_idx` counts 0,1,2,3 on advances and then wraps to 0, and the address returns to the loaded start value on the fourth advance.
- R6: Advance cycles never change `acc_addr` bits above bit 1.
- R7: A cycle with `hold` = 1 keeps `acc_addr` and `beat_idx` unchanged, whatever the values of `adv`, `ext_addr` and `ilv_mode`.
- R8: A load during a burst abandons that burst. The new start is taken and `beat_idx` restarts at 0.
- R9: Start offset 01 gives the sequence 01,00,11,10 in interleaved order and 01,10,11,00 in linear order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Stall: 1 freezes all state |
| adv | input | 1 | 0 = load `ext_addr`, 1 = step to next beat |
| ilv_mode | input | 1 | Order select: 0 linear, 1 interleaved (static) |
| ext_addr | input | ADDR_W | External starting address |
| acc_addr | output | ADDR_W | Registered current access address |
| beat_idx | output | BEAT_W | Registered beat index within the burst |

## Verification
Each result is registered once. A load, an advance or a stall sampled at rising edge k therefore shows on `acc_addr` and `beat_idx` directly after edge k, and no later edge is involved. The bench changes inputs on the falling edge, waits for the next rising edge, and compares 1 ns later, so every comparison covers exactly one edge's effect. Expected addresses come from the start value and a bench-side beat count using the add and XOR rules.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  assign beat_nxt = clr ? '0 : beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)     beat_q <= '0;
    else if (en) beat_q <= beat_nxt;
  end

  // R5
  beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && beat_q == LAST) |=> (beat_q == '0));
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_addr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_out
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  genvar g;
  generate
    for (g = 0; g < BEAT_W; g++) begin : g_xor_bit
      assign xor_low[g] = start_low[g] ^ beat[g];
    end
  endgenerate

  assign lin_low = start_low + beat;

  always_comb begin
    case (order)
      ORD_XOR: low_out = xor_low;
      default: low_out = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic                        adv,
  input  logic                        ilv_mode,
  input  logic [ADDR_W-1:0]           ext_addr,
  output logic [ADDR_W-1:0]           acc_addr,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx
);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              step_en;
  logic              load;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] low_q;
  logic [BEAT_W-1:0] low_nxt;
  logic [BEAT_W-1:0] beat_nxt;
  logic [HI_W-1:0]   hi_q;
  burst_order_e      order;

  assign step_en = !hold;
  assign load    = !adv;
  assign order   = burst_order_e'(ilv_mode);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .en       (step_en),
    .clr      (load),
    .beat_q   (beat_idx),
    .beat_nxt (beat_nxt)
  );

  burst_low_map #(.BEAT_W(BEAT_W)) u_map (
    .order     (order),
    .start_low (start_q),
    .beat      (beat_nxt),
    .low_out   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      low_q   <= '0;
      hi_q    <= '0;
    end else if (step_en) begin
      if (load) begin
        start_q <= ext_addr[BEAT_W-1:0];
        low_q   <= ext_addr[BEAT_W-1:0];
        hi_q    <= ext_addr[ADDR_W-1:BEAT_W];
      end else begin
        low_q   <= low_nxt;
      end
    end
  end

  assign acc_addr = {hi_q, low_q};

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(acc_addr) && $stable(beat_idx)));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !adv) |=> (acc_addr == $past(ext_addr) && beat_idx == '0));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv) |=> (acc_addr[ADDR_W-1:BEAT_W] == $past(acc_addr[ADDR_W-1:BEAT_W])));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv && !ilv_mode) |=>
      (acc_addr[BEAT_W-1:0] == BEAT_W'($past(acc_addr[BEAT_W-1:0]) + 1'b1)));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv) |=> (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          hold;
  logic          adv;
  logic          ilv_mode;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] acc_addr;
  logic [1:0]    beat_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .adv      (adv),
    .ilv_mode (ilv_mode),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr),
    .beat_idx (beat_idx)
  );

  task automatic check(string req, logic [AW-1:0] a_exp, logic [1:0] b_exp);
    n_checks++;
    if (acc_addr !== a_exp || beat_idx !== b_exp) begin
      n_errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, acc_addr, beat_idx, a_exp, b_exp);
    end
  endtask

  task automatic cyc(logic h, logic a, logic m, logic [AW-1:0] ad);
    @(negedge clk);
    hold = h; adv = a; ilv_mode = m; ext_addr = ad;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] model(logic [AW-1:0] s, logic [1:0] b, logic m);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ b) : 2'(s[1:0] + b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; hold = 1'b0; adv = 1'b0; ilv_mode = 1'b0; ext_addr = 20'hABCDE;
    @(posedge clk); #1;
    check("R1 reset", '0, 2'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_burst(string req, logic m, logic [AW-1:0] s);
    cyc(1'b0, 1'b0, m, s);
    check({req, " R2 load"}, s, 2'd0);
    for (int b = 1; b < 4; b++) begin
      cyc(1'b0, 1'b1, m, ~s);
      check({req, " R6 step"}, model(s, 2'(b), m), 2'(b));
    end
    cyc(1'b0, 1'b1, m, 20'h0);
    check("R5 wrap to start", s, 2'd0);
  endtask

  task automatic t_examples();
    logic [1:0] ilv_seq [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    logic [1:0] lin_seq [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    cyc(1'b0, 1'b0, 1'b1, 20'h00011);
    for (int b = 0; b < 4; b++) begin
      if (b > 0) cyc(1'b0, 1'b1, 1'b1, 20'h0);
      check("R9 interleaved example", {18'h00004, ilv_seq[b]}, 2'(b));
    end
    cyc(1'b0, 1'b0, 1'b0, 20'h00011);
    for (int b = 0; b < 4; b++) begin
      if (b > 0) cyc(1'b0, 1'b1, 1'b0, 20'h0);
      check("R9 linear example", {18'h00004, lin_seq[b]}, 2'(b));
    end
  endtask

  task automatic t_stall();
    cyc(1'b0, 1'b0, 1'b0, 20'h12342);
    cyc(1'b0, 1'b1, 1'b0, 20'h0);
    check("R7 pre-stall", 20'h12343, 2'd1);
    cyc(1'b1, 1'b0, 1'b1, 20'hFFFFF);
    check("R7 stall with load pattern", 20'h12343, 2'd1);
    cyc(1'b1, 1'b1, 1'b1, 20'h55555);
    check("R7 stall with advance pattern", 20'h12343, 2'd1);
    cyc(1'b0, 1'b1, 1'b0, 20'h0);
    check("R7 resume after stall", 20'h12340, 2'd2);
  endtask

  task automatic t_reload();
    cyc(1'b0, 1'b0, 1'b1, 20'h0F0F2);
    cyc(1'b0, 1'b1, 1'b1, 20'h0);
    cyc(1'b0, 1'b1, 1'b1, 20'h0);
    check("R4 mid burst", 20'h0F0F0, 2'd2);
    cyc(1'b0, 1'b0, 1'b1, 20'hA5A53);
    check("R8 reload mid burst", 20'hA5A53, 2'd0);
    cyc(1'b0, 1'b1, 1'b1, 20'h0);
    check("R8 new burst step", 20'hA5A52, 2'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hold = 1'b0; adv = 1'b0; ilv_mode = 1'b0; ext_addr = '0;
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_burst("R3 linear", 1'b0, 20'h3C5A0 | 20'(s));
      t_burst("R4 interleaved", 1'b1, 20'h81230 | 20'(s));
    end
    t_examples();
    t_stall();
    t_reload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule